// File: doc/BRIEF.md
# Pulse Edge Timestamp Capture Unit

This block timestamps randomly arriving pulses against a free-running time base. A single counter advances once per clock. When the shaped pulse input goes high, the counter value is stored as the arrival stamp. When the input goes low, the counter value is stored in a second, independent register as the end stamp. The pulse width is the difference between the two stamps, modulo the counter width. A once-per-hour reference tick clears the counter, so stamps are relative to the last tick.

The pulse input is resynchronised through a flop chain, so both edges carry the same fixed latency and the width comes out exact. A finished measurement is held on a valid/ready readout until the consumer takes it. A pulse that starts while a result is still waiting is dropped, and a sticky overrun flag is raised.

Top module: `pulse_stamp_unit`

## Requirements
- R1: After reset the time counter starts at 0 and advances by exactly one per clock, wrapping modulo 2^CNT_W.
- R2: A high `hour_tick` sampled at a clock edge makes the counter read 0 in the following cycle, and counting resumes from there.
- R3: `pulse_in` passes through a two-flop synchroniser. Let v be the counter value in the cycle in which the input is first driven high. The arrival stamp `rd_arrival` is then v+2.
- R4: Let w be the counter value in the cycle in which the input is first driven low. The end stamp `rd_end` is then w+2, captured into a register separate from the arrival stamp.
- R5: `rd_width` equals `rd_end` minus `rd_arrival` modulo 2^CNT_W, and stays correct when the counter wraps between the two edges.
- R6: `rd_valid` goes high in the cycle the end stamp is captured. It stays high, with all three outputs stable, until a clock edge sees `rd_valid` and `rd_ready` both high, and reads 0 in the cycle after that.
- R7: A pulse held high for a single clock cycle is measured with width 1.
- R8: A rising edge seen while a result is pending and not being accepted in that cycle sets `overrun` and leaves the pending stamps unchanged. The end of that dropped pulse is also ignored. `overrun` clears when the result is accepted, and the next pulse is measured normally.
- R9: When `hour_tick` coincides with the cycle in which an edge is captured, the reset wins and that stamp records 0.
- R10: During and right after reset, `rd_valid` and `overrun` are 0 and all three data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Shaped pulse level, asynchronous to clk |
| hour_tick | input | 1 | One-cycle reference tick that clears the time counter |
| rd_ready | input | 1 | Consumer accepts the pending result |
| rd_valid | output | 1 | A measurement is pending |
| rd_arrival | output | CNT_W | Counter value captured at the rising edge |
| rd_end | output | CNT_W | Counter value captured at the falling edge |
| rd_width | output | CNT_W | End stamp minus arrival stamp, modulo 2^CNT_W |
| overrun | output | 1 | Sticky flag for a pulse dropped while a result was pending |

## Verification
The assertions assume that `hour_tick` is a single-cycle strobe that is synchronous to `clk`. They also assume that a fall can only follow its own rise, and that the synchroniser output is the only source of edges. The bench drives every input on the falling clock edge and keeps `hour_tick` to one cycle. It separates pulses by enough low cycles for each falling edge to clear the synchroniser before the next rise. A second instance with an 8-bit counter reaches a real wrap within the run.

// File: rtl/pst_pkg.sv
package pst_pkg;

  localparam int unsigned MAX_W = 64;

  // Modulo difference between two stamps; callers keep the low CNT_W bits.
  function automatic logic [MAX_W-1:0] stamp_span(input logic [MAX_W-1:0] later,
                                                  input logic [MAX_W-1:0] earlier);
    return later - earlier;
  endfunction

endpackage

// File: rtl/pst_sync_edge.sv
module pst_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_evt,
  output logic fall_evt
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level    = chain_q[STAGES-1];
  assign rise_evt = level & ~prev_q;
  assign fall_evt = ~level & prev_q;

  // R3: a detected rise lasts one cycle only
  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);

  // R4: a detected fall lasts one cycle only
  assert_fall_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);

endmodule

// File: rtl/pst_timebase.sv
module pst_timebase #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hour_tick,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (hour_tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count = cnt_q;

  // R1: steady advance between ticks
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hour_tick |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R2: the reference tick clears the time base
  assert_tick_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hour_tick |=> (cnt_q == '0));

endmodule

// File: rtl/pst_capture.sv
module pst_capture #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             hour_tick,
  input  logic [CNT_W-1:0] count,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [CNT_W-1:0] arr_stamp,
  output logic [CNT_W-1:0] end_stamp,
  output logic             overrun
);

  logic             valid_q;
  logic             armed_q;
  logic             drop_q;
  logic             ovr_q;
  logic [CNT_W-1:0] arr_q;
  logic [CNT_W-1:0] end_q;
  logic             accept;
  logic             take_rise;
  logic             lose_rise;
  logic             take_fall;
  logic [CNT_W-1:0] stamp;

  assign accept    = valid_q & rd_ready;
  assign take_rise = rise_evt & (~valid_q | accept);
  assign lose_rise = rise_evt & valid_q & ~accept;
  assign take_fall = fall_evt & armed_q & ~drop_q;
  // The reference tick wins over an edge in the same cycle.
  assign stamp     = hour_tick ? '0 : count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      armed_q <= 1'b0;
      drop_q  <= 1'b0;
      ovr_q   <= 1'b0;
      arr_q   <= '0;
      end_q   <= '0;
    end else begin
      if (accept) begin
        valid_q <= 1'b0;
        ovr_q   <= 1'b0;
      end
      if (take_rise) begin
        arr_q   <= stamp;
        armed_q <= 1'b1;
      end
      if (lose_rise) begin
        ovr_q  <= 1'b1;
        drop_q <= 1'b1;
      end
      if (fall_evt && drop_q) drop_q <= 1'b0;
      if (take_fall) begin
        end_q   <= stamp;
        valid_q <= 1'b1;
        armed_q <= 1'b0;
      end
    end
  end

  assign rd_valid  = valid_q;
  assign arr_stamp = arr_q;
  assign end_stamp = end_q;
  assign overrun   = ovr_q;

  // R6: an armed falling edge publishes a result
  assert_fall_publishes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && armed_q && !drop_q) |=> valid_q);

  // R6: acceptance retires the result
  assert_accept_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && rd_ready && !fall_evt) |=> !valid_q);

  // R8: a pending result is frozen until taken
  assert_hold_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !rd_ready) |=> ($stable(arr_q) && $stable(end_q) && valid_q));

  // R8: a rise against a pending result raises the sticky flag
  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && valid_q && !rd_ready) |=> ovr_q);

  // R9: tick coinciding with a captured rise stores zero
  assert_tick_rise_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && hour_tick && (!valid_q || rd_ready)) |=> (arr_q == '0));

endmodule

// File: rtl/pulse_stamp_unit.sv
module pulse_stamp_unit #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic             hour_tick,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_arrival,
  output logic [CNT_W-1:0] rd_end,
  output logic [CNT_W-1:0] rd_width,
  output logic             overrun
);

  localparam int unsigned PAD_W = pst_pkg::MAX_W - CNT_W;

  logic                      rise_evt;
  logic                      fall_evt;
  logic [CNT_W-1:0]          time_now;
  logic [pst_pkg::MAX_W-1:0] span_full;

  pst_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (pulse_in),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  pst_timebase #(.CNT_W(CNT_W)) u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .hour_tick (hour_tick),
    .count     (time_now)
  );

  pst_capture #(.CNT_W(CNT_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .hour_tick (hour_tick),
    .count     (time_now),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .arr_stamp (rd_arrival),
    .end_stamp (rd_end),
    .overrun   (overrun)
  );

  assign span_full = pst_pkg::stamp_span({{PAD_W{1'b0}}, rd_end}, {{PAD_W{1'b0}}, rd_arrival});
  assign rd_width  = span_full[CNT_W-1:0];

  // R10: nothing pending or flagged straight after reset
  assert_reset_quiet_R10: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rd_valid && !overrun));

  // R5: width is stable whenever both stamps are stable
  assert_width_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_arrival) && $stable(rd_end)) |-> $stable(rd_width));

endmodule

// File: tb/pulse_stamp_unit_bench.sv
module pulse_stamp_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse_in = 1'b0;
  logic        hour_tick = 1'b0;
  logic        rd_ready = 1'b0;
  logic        rd_valid, overrun;
  logic [31:0] rd_arrival, rd_end, rd_width;
  logic        n_valid, n_overrun;
  logic [7:0]  n_arrival, n_end, n_width;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [31:0] tcnt;

  always #4 clk = ~clk;

  pulse_stamp_unit u_pulse_stamp_unit (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .hour_tick(hour_tick),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_arrival(rd_arrival),
    .rd_end(rd_end), .rd_width(rd_width), .overrun(overrun));

  pulse_stamp_unit #(.CNT_W(8)) u_pulse_stamp_unit_narrow (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .hour_tick(hour_tick),
    .rd_ready(rd_ready), .rd_valid(n_valid), .rd_arrival(n_arrival),
    .rd_end(n_end), .rd_width(n_width), .overrun(n_overrun));

  // Time reference from R1/R2: zero after reset, +1 per clock, zero after a tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tcnt <= '0;
    else if (hour_tick) tcnt <= '0;
    else                tcnt <= tcnt + 32'd1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_pulse(input int len, output logic [31:0] ta, output logic [31:0] tf);
    @(negedge clk); pulse_in = 1'b1; ta = tcnt;
    repeat (len) @(negedge clk);
    pulse_in = 1'b0; tf = tcnt;
  endtask

  task automatic wait_valid();
    for (int k = 0; k < 20 && !rd_valid; k++) @(negedge clk);
  endtask

  task automatic take(input string req);
    @(negedge clk); rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0;
    check(req, {31'd0, rd_valid}, 32'd0);
  endtask

  localparam int unsigned NV = 6;
  // {low gap before pulse, high length}
  localparam int unsigned VEC [NV][2] = '{'{5, 1}, '{4, 2}, '{7, 13}, '{3, 100}, '{9, 5}, '{6, 3}};

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] ta, tf, a0, e0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", {31'd0, rd_valid}, 32'd0);
    check("R10 overrun", {31'd0, overrun}, 32'd0);
    check("R10 arrival", rd_arrival, 32'd0);
    check("R10 width", rd_width, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      repeat (VEC[i][0]) @(negedge clk);
      run_pulse(VEC[i][1], ta, tf);
      wait_valid();
      check("R6 valid", {31'd0, rd_valid}, 32'd1);
      check("R3 arrival", rd_arrival, ta + 32'd2);
      check("R4 end", rd_end, tf + 32'd2);
      check(VEC[i][1] == 1 ? "R7 width" : "R5 width", rd_width, VEC[i][1]);
      take("R6 accept");
    end

    // R8 overrun
    run_pulse(4, ta, tf);
    wait_valid();
    a0 = ta + 32'd2; e0 = tf + 32'd2;
    repeat (4) @(negedge clk);
    run_pulse(6, ta, tf);
    repeat (8) @(negedge clk);
    check("R8 held arrival", rd_arrival, a0);
    check("R8 held end", rd_end, e0);
    check("R8 flag", {31'd0, overrun}, 32'd1);
    check("R6 still valid", {31'd0, rd_valid}, 32'd1);
    take("R8 accept");
    check("R8 flag cleared", {31'd0, overrun}, 32'd0);
    repeat (3) @(negedge clk);
    run_pulse(7, ta, tf);
    wait_valid();
    check("R8 next arrival", rd_arrival, ta + 32'd2);
    check("R8 next width", rd_width, 32'd7);
    take("R8 accept2");

    // R9 / R2: tick together with the captured rise
    repeat (4) @(negedge clk);
    @(negedge clk); pulse_in = 1'b1;
    @(negedge clk);
    @(negedge clk); hour_tick = 1'b1;
    @(negedge clk); hour_tick = 1'b0;
    repeat (8) @(negedge clk);
    pulse_in = 1'b0; tf = tcnt;
    wait_valid();
    check("R9 rise zero", rd_arrival, 32'd0);
    check("R2 end after tick", rd_end, tf + 32'd2);
    check("R5 width after tick", rd_width, tf + 32'd2);
    take("R9 accept");

    // R9: tick together with the captured fall
    repeat (4) @(negedge clk);
    @(negedge clk); pulse_in = 1'b1; ta = tcnt;
    repeat (10) @(negedge clk);
    pulse_in = 1'b0;
    @(negedge clk);
    @(negedge clk); hour_tick = 1'b1;
    @(negedge clk); hour_tick = 1'b0;
    wait_valid();
    check("R9 fall zero", rd_end, 32'd0);
    check("R9 arrival", rd_arrival, ta + 32'd2);
    check("R5 negative span", rd_width, 32'd0 - (ta + 32'd2));
    take("R9 accept2");

    // R5 / R1: wrap on the 8-bit instance
    while (tcnt[7:0] != 8'd230) @(negedge clk);
    pulse_in = 1'b1; ta = tcnt;
    repeat (40) @(negedge clk);
    pulse_in = 1'b0;
    wait_valid();
    check("R1 wrap arrival", {24'd0, n_arrival}, 32'd232);
    check("R1 wrap end", {24'd0, n_end}, 32'd16);
    check("R5 wrap width", {24'd0, n_width}, 32'd40);
    check("R5 wide width", rd_width, 32'd40);
    take("R6 accept wrap");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule